// File: doc/BRIEF.md
# Status Queue Writer with Overflow

This block places fixed-format status entries into a set of circular queues that live in host memory. Each queue has a base address, a power-of-two size (4 to 256 entries) and a group bit that selects which of two interrupt domains it reports into. The hardware owns a write index per queue. The host owns a stored read index per queue, which it refreshes only now and then through the register port. Every entry that goes out carries a valid flag and an overflow flag above the caller's payload.

Fullness is judged against the stored read index, which may lag behind the host. One slot is always kept unused. The block does not refuse the write that uses the last free slot. Instead it sets the overflow flag inside that entry and raises a sticky full bit in the high-priority or the low-priority interrupt register. Requests to a queue that is already full are dropped until the host moves the stored read index forward. A global strap turns the whole full check off.

Every write also sets a sticky summary bit, and queues 0 to 15 each set their own bit in a 16-bit source register. All interrupt bits are cleared by write-1-to-clear host accesses.

Top module: `sq_status_writer`

## Requirements
- R1: A request accepted at a clock edge produces, visible after that edge, a one-cycle `mem_we` pulse with `mem_addr` = base of the queue + write index, and `mem_data` = {valid=1 at bit PW+1, overflow flag at bit PW, payload in bits PW-1:0}.
- R2: After each write the queue's write index advances by one and wraps to 0 at 2^`cfg_size_lg`.
- R3: Let W be the write index after the increment and R the stored read index. The write for which (W+1) mod size equals R carries overflow flag 1. All other writes carry 0.
- R4: While (write index + 1) mod size equals R, requests to that queue make no memory write and do not move the index. Writing resumes once the host moves R.
- R5: A write that carries the overflow flag sets `hi_stat` bit 1 if the queue's `cfg_lo_grp` bit is 0. If that bit is 1, it sets `lo_stat` instead.
- R6: Every write sets `hi_stat` bit 0. A write to queue q < 16 sets `wr_src` bit q. Queues 16 and above leave `wr_src` unchanged.
- R7: With `cfg_stat_dis` = 1 there is no full check. Every request is written with overflow flag 0, no full bit is set, and the index wraps freely.
- R8: Interrupt bits are sticky. A host access with `host_op` 1 clears the `hi_stat` bits set in `host_data[1:0]`. Op 2 clears `lo_stat` if `host_data[0]` is 1. Op 3 clears the `wr_src` bits set in `host_data[15:0]`. A bit set and cleared in the same cycle stays set.
- R9: Reset clears all write and read indices, all interrupt bits and `mem_we`.
- R10: `irq_hi` is high while any `hi_stat` bit is set. `irq_lo` is high while `lo_stat` is set.
- R11: A host access with `host_op` 0 loads `host_data[7:0]`, masked to the queue size, as the stored read index of `host_queue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stat_dis | input | 1 | Disables full checking for all queues |
| cfg_size_lg | input | NQ x 4 | Per-queue log2 of queue size (2..8) |
| cfg_lo_grp | input | NQ | Per-queue: 1 routes full to low-priority register |
| cfg_base | input | NQ x AW | Per-queue base word address |
| req_valid | input | 1 | Entry request strobe |
| req_queue | input | QW | Target queue of the request |
| req_payload | input | PW | Entry payload |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_data | output | PW+2 | Entry word {valid, overflow, payload} |
| host_wr | input | 1 | Host register access strobe |
| host_op | input | 2 | 0 set read index, 1 clear high reg, 2 clear low reg, 3 clear source reg |
| host_queue | input | QW | Queue for read-index update |
| host_data | input | 16 | Read index value or clear mask |
| hi_stat | output | 2 | High-priority register: bit 1 full, bit 0 write summary |
| lo_stat | output | 1 | Low-priority register: full |
| wr_src | output | 16 | Per-queue write source bits, queues 0..15 |
| irq_hi | output | 1 | High-priority interrupt |
| irq_lo | output | 1 | Low-priority interrupt |

## Verification
The assertions rely on the configuration straps staying steady for the whole cycle in which a request is taken. They also rely on `cfg_size_lg` staying within 2 to 8, and on the low-priority full bit being cleared only through the host port. The bench drives every input on the falling edge and holds the straps fixed, except for `cfg_stat_dis`, which it changes only while no request is pending. Queue numbers stay below NQ, and read-index values are chosen so that the expected write pattern can be worked out by hand.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
    localparam int IDXW  = 8;   // enough for 256 entries
    localparam int SRC_W = 16;  // queues reported in source register

    typedef enum logic [1:0] {
        HOP_SET_RD  = 2'd0,
        HOP_CLR_HI  = 2'd1,
        HOP_CLR_LO  = 2'd2,
        HOP_CLR_SRC = 2'd3
    } host_op_e;

    typedef struct packed {
        logic            blocked;     // queue is full, drop request
        logic            enter_full;  // this write uses the last slot
        logic [IDXW-1:0] next_idx;    // write index after increment
    } slot_eval_t;

    function automatic logic [IDXW-1:0] idx_mask(input logic [3:0] lg);
        logic [IDXW:0] span;
        span = (IDXW+1)'(1) << lg;
        return IDXW'(span - (IDXW+1)'(1));
    endfunction
endpackage

// File: rtl/sqw_idx_table.sv
module sqw_idx_table
    import sqw_pkg::*;
#(
    parameter int NQ = 20,
    parameter int QW = $clog2(NQ)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [QW-1:0]             wr_q,
    input  logic [IDXW-1:0]           wr_val,
    input  logic                      rd_en,
    input  logic [QW-1:0]             rd_q,
    input  logic [IDXW-1:0]           rd_val,
    output logic [NQ-1:0][IDXW-1:0]   wr_idx,
    output logic [NQ-1:0][IDXW-1:0]   rd_idx
);
    for (genvar i = 0; i < NQ; i++) begin : g_q
        always_ff @(posedge clk) begin
            if (rst) begin
                wr_idx[i] <= '0;
                rd_idx[i] <= '0;
            end else begin
                if (wr_en && wr_q == QW'(i)) wr_idx[i] <= wr_val;
                if (rd_en && rd_q == QW'(i)) rd_idx[i] <= rd_val;
            end
        end
    end
endmodule

// File: rtl/sqw_slot_eval.sv
module sqw_slot_eval
    import sqw_pkg::*;
(
    input  logic [IDXW-1:0] wr_idx,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [3:0]      size_lg,
    input  logic            dis,
    output slot_eval_t      ev
);
    logic [IDXW-1:0] mask, nxt, after;

    always_comb begin
        mask  = idx_mask(size_lg);
        nxt   = (wr_idx + IDXW'(1)) & mask;
        after = (nxt + IDXW'(1)) & mask;
        ev.next_idx   = nxt;
        ev.blocked    = !dis && (nxt == rd_idx);
        ev.enter_full = !dis && (after == rd_idx);
    end
endmodule

// File: rtl/sqw_irq_bank.sv
module sqw_irq_bank
    import sqw_pkg::*;
#(
    parameter int QW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_evt,
    input  logic [QW-1:0]    wr_q,
    input  logic             full_evt,
    input  logic             full_lo,
    input  logic             host_wr,
    input  host_op_e         host_op,
    input  logic [15:0]      host_data,
    output logic [1:0]       hi_stat,
    output logic             lo_stat,
    output logic [SRC_W-1:0] wr_src
);
    logic [1:0]       hi_set, hi_clr;
    logic             lo_set, lo_clr;
    logic [SRC_W-1:0] src_set, src_clr;

    always_comb begin
        hi_set  = {full_evt && !full_lo, wr_evt};
        lo_set  = full_evt && full_lo;
        hi_clr  = (host_wr && host_op == HOP_CLR_HI)  ? host_data[1:0] : 2'b00;
        lo_clr  = host_wr && host_op == HOP_CLR_LO && host_data[0];
        src_clr = (host_wr && host_op == HOP_CLR_SRC) ? host_data[SRC_W-1:0] : '0;
    end

    for (genvar i = 0; i < SRC_W; i++) begin : g_src
        assign src_set[i] = wr_evt && (32'(wr_q) == i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_stat <= '0;
            lo_stat <= 1'b0;
            wr_src  <= '0;
        end else begin
            hi_stat <= (hi_stat & ~hi_clr) | hi_set;
            lo_stat <= (lo_stat & ~lo_clr) | lo_set;
            wr_src  <= (wr_src & ~src_clr) | src_set;
        end
    end
endmodule

// File: rtl/sq_status_writer.sv
module sq_status_writer
    import sqw_pkg::*;
#(
    parameter int NQ = 20,
    parameter int PW = 16,
    parameter int AW = 16,
    parameter int QW = $clog2(NQ)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_stat_dis,
    input  logic [NQ-1:0][3:0]       cfg_size_lg,
    input  logic [NQ-1:0]            cfg_lo_grp,
    input  logic [NQ-1:0][AW-1:0]    cfg_base,
    input  logic                     req_valid,
    input  logic [QW-1:0]            req_queue,
    input  logic [PW-1:0]            req_payload,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [PW+1:0]            mem_data,
    input  logic                     host_wr,
    input  logic [1:0]               host_op,
    input  logic [QW-1:0]            host_queue,
    input  logic [15:0]              host_data,
    output logic [1:0]               hi_stat,
    output logic                     lo_stat,
    output logic [15:0]              wr_src,
    output logic                     irq_hi,
    output logic                     irq_lo
);
    logic [NQ-1:0][IDXW-1:0] wr_idx, rd_idx;
    logic [QW-1:0]           rq, hq;
    logic                    rq_ok, hq_ok, do_write, rd_load;
    logic [IDXW-1:0]         rd_new;
    slot_eval_t              ev;
    host_op_e                hop;

    assign hop   = host_op_e'(host_op);
    assign rq_ok = 32'(req_queue) < NQ;
    assign hq_ok = 32'(host_queue) < NQ;
    assign rq    = rq_ok ? req_queue : '0;
    assign hq    = hq_ok ? host_queue : '0;

    sqw_slot_eval u_eval (
        .wr_idx  (wr_idx[rq]),
        .rd_idx  (rd_idx[rq]),
        .size_lg (cfg_size_lg[rq]),
        .dis     (cfg_stat_dis),
        .ev      (ev)
    );

    assign do_write = req_valid && rq_ok && !ev.blocked;
    assign rd_load  = host_wr && hq_ok && hop == HOP_SET_RD;
    assign rd_new   = host_data[IDXW-1:0] & idx_mask(cfg_size_lg[hq]);

    sqw_idx_table #(.NQ(NQ), .QW(QW)) u_tab (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (do_write),
        .wr_q   (rq),
        .wr_val (ev.next_idx),
        .rd_en  (rd_load),
        .rd_q   (hq),
        .rd_val (rd_new),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx)
    );

    sqw_irq_bank #(.QW(QW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .wr_evt    (do_write),
        .wr_q      (rq),
        .full_evt  (do_write && ev.enter_full),
        .full_lo   (cfg_lo_grp[rq]),
        .host_wr   (host_wr),
        .host_op   (hop),
        .host_data (host_data),
        .hi_stat   (hi_stat),
        .lo_stat   (lo_stat),
        .wr_src    (wr_src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= do_write;
            if (do_write) begin
                mem_addr <= cfg_base[rq] + AW'(wr_idx[rq]);
                mem_data <= {1'b1, ev.enter_full, req_payload};
            end
        end
    end

    assign irq_hi = |hi_stat;
    assign irq_lo = lo_stat;
endmodule

// File: rtl/sqw_checker.sv
module sqw_checker #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          cfg_stat_dis,
    input logic          mem_we,
    input logic [PW+1:0] mem_data,
    input logic [1:0]    hi_stat,
    input logic          lo_stat,
    input logic          host_wr,
    input logic [1:0]    host_op
);
    p_write_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(req_valid));

    p_entry_valid_r1: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_data[PW+1]);

    p_ovfl_raises_full_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_data[PW]) |-> (hi_stat[1] || lo_stat));

    p_dis_no_ovfl_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(cfg_stat_dis)) |-> !mem_data[PW]);

    p_summary_set_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> hi_stat[0]);

    p_lo_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(lo_stat) |-> $past(host_wr && host_op == 2'd2));
endmodule

bind sq_status_writer sqw_checker #(.PW(PW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .cfg_stat_dis (cfg_stat_dis),
    .mem_we       (mem_we),
    .mem_data     (mem_data),
    .hi_stat      (hi_stat),
    .lo_stat      (lo_stat),
    .host_wr      (host_wr),
    .host_op      (host_op)
);

// File: tb/tb_sq_status_writer.sv
module tb_sq_status_writer;
    localparam int NQ = 20;
    localparam int PW = 16;
    localparam int AW = 16;
    localparam int QW = $clog2(NQ);

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  cfg_stat_dis;
    logic [NQ-1:0][3:0]    cfg_size_lg;
    logic [NQ-1:0]         cfg_lo_grp;
    logic [NQ-1:0][AW-1:0] cfg_base;
    logic                  req_valid;
    logic [QW-1:0]         req_queue;
    logic [PW-1:0]         req_payload;
    logic                  mem_we;
    logic [AW-1:0]         mem_addr;
    logic [PW+1:0]         mem_data;
    logic                  host_wr;
    logic [1:0]            host_op;
    logic [QW-1:0]         host_queue;
    logic [15:0]           host_data;
    logic [1:0]            hi_stat;
    logic                  lo_stat;
    logic [15:0]           wr_src;
    logic                  irq_hi, irq_lo;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    sq_status_writer #(.NQ(NQ), .PW(PW), .AW(AW)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic send(input int q, input logic [15:0] pl);
        @(negedge clk);
        req_valid = 1'b1; req_queue = QW'(q); req_payload = pl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic host(input logic [1:0] op, input int q, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_op = op; host_queue = QW'(q); host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic expect_write(input string tag, input logic [15:0] addr,
                                input logic ovfl, input logic [15:0] pl);
        chk({tag, " we"}, 32'(mem_we), 1);
        chk({tag, " addr"}, 32'(mem_addr), 32'(addr));
        chk({tag, " data"}, 32'(mem_data), 32'({1'b1, ovfl, pl}));
    endtask

    task automatic t_reset();
        chk("R9 mem_we", 32'(mem_we), 0);
        chk("R9 hi_stat", 32'(hi_stat), 0);
        chk("R9 lo_stat", 32'(lo_stat), 0);
        chk("R9 wr_src", 32'(wr_src), 0);
        chk("R10 irq idle", 32'({irq_hi, irq_lo}), 0);
    endtask

    task automatic t_fill_q0();
        send(0, 16'hA001); expect_write("R1 q0 first", 16'h0100, 1'b0, 16'hA001);
        chk("R6 summary", 32'(hi_stat), 32'b01);
        send(0, 16'hA002); expect_write("R2 q0 second", 16'h0101, 1'b0, 16'hA002);
        send(0, 16'hA003); expect_write("R3 q0 last slot", 16'h0102, 1'b1, 16'hA003);
        chk("R5 hi full", 32'(hi_stat), 32'b11);
        chk("R5 lo untouched", 32'(lo_stat), 0);
        chk("R10 irq_hi", 32'(irq_hi), 1);
        chk("R6 src q0", 32'(wr_src), 32'h0001);
    endtask

    task automatic t_drop_and_resume();
        send(0, 16'hA004); chk("R4 dropped while full", 32'(mem_we), 0);
        host(2'd0, 0, 16'd2);
        send(0, 16'hB001); expect_write("R11 after rd update", 16'h0103, 1'b0, 16'hB001);
        send(0, 16'hB002); expect_write("R2 wrap to base", 16'h0100, 1'b1, 16'hB002);
        send(0, 16'hB003); chk("R4 full again", 32'(mem_we), 0);
    endtask

    task automatic t_lo_group();
        host(2'd1, 0, 16'h0003);
        chk("R8 clear hi", 32'(hi_stat), 0);
        chk("R10 irq_hi low", 32'(irq_hi), 0);
        for (int k = 0; k < 7; k++) begin
            send(1, 16'(16'hC000 + k));
            expect_write("R3 q1 fill", 16'(16'h0200 + k), (k == 6), 16'(16'hC000 + k));
        end
        chk("R5 lo full", 32'(lo_stat), 1);
        chk("R5 hi full not set", 32'(hi_stat), 32'b01);
        chk("R10 irq_lo", 32'(irq_lo), 1);
        chk("R6 src q0 q1", 32'(wr_src), 32'h0003);
    endtask

    task automatic t_high_queue();
        host(2'd3, 0, 16'hFFFF);
        chk("R8 clear src", 32'(wr_src), 0);
        send(17, 16'hD001); expect_write("R1 q17", 16'h0300, 1'b0, 16'hD001);
        chk("R6 q17 no src bit", 32'(wr_src), 0);
        chk("R6 q17 summary", 32'(hi_stat[0]), 1);
    endtask

    task automatic t_w1c();
        host(2'd2, 0, 16'h0000);
        chk("R8 zero mask keeps lo", 32'(lo_stat), 1);
        host(2'd2, 0, 16'h0001);
        chk("R8 lo cleared", 32'(lo_stat), 0);
        chk("R10 irq_lo low", 32'(irq_lo), 0);
        @(negedge clk);
        req_valid = 1'b1; req_queue = QW'(2); req_payload = 16'hE001;
        host_wr = 1'b1; host_op = 2'd1; host_data = 16'h0003;
        @(negedge clk);
        req_valid = 1'b0; host_wr = 1'b0;
        chk("R8 set wins over clear", 32'(hi_stat), 32'b01);
        chk("R6 q2 src", 32'(wr_src), 32'h0004);
    endtask

    task automatic t_disable();
        host(2'd1, 0, 16'h0003);
        cfg_stat_dis = 1'b1;
        send(17, 16'hF001); expect_write("R7 dis w1", 16'h0301, 1'b0, 16'hF001);
        send(17, 16'hF002); expect_write("R7 dis w2", 16'h0302, 1'b0, 16'hF002);
        send(17, 16'hF003); expect_write("R7 dis w3", 16'h0303, 1'b0, 16'hF003);
        send(17, 16'hF004); expect_write("R7 dis wrap", 16'h0300, 1'b0, 16'hF004);
        send(17, 16'hF005); expect_write("R7 dis past rd", 16'h0301, 1'b0, 16'hF005);
        chk("R7 no full bit", 32'({hi_stat[1], lo_stat}), 0);
        @(negedge clk);
        cfg_stat_dis = 1'b0;
        send(17, 16'hF006); expect_write("R3 q17 enabled", 16'h0302, 1'b1, 16'hF006);
        chk("R5 q17 hi full", 32'(hi_stat[1]), 1);
    endtask

    task automatic t_mask();
        host(2'd0, 0, 16'h00FF);
        send(0, 16'h5A5A); expect_write("R11 masked rd", 16'h0101, 1'b1, 16'h5A5A);
        send(0, 16'h5A5B); chk("R4 masked full", 32'(mem_we), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_stat_dis = 1'b0;
        req_valid = 1'b0; req_queue = '0; req_payload = '0;
        host_wr = 1'b0; host_op = '0; host_queue = '0; host_data = '0;
        for (int q = 0; q < NQ; q++) begin
            cfg_size_lg[q] = 4'd4;
            cfg_lo_grp[q]  = 1'b0;
            cfg_base[q]    = AW'(16'h1000 + q * 64);
        end
        cfg_size_lg[0] = 4'd2; cfg_base[0]  = 16'h0100;
        cfg_size_lg[1] = 4'd3; cfg_base[1]  = 16'h0200; cfg_lo_grp[1] = 1'b1;
        cfg_size_lg[17] = 4'd2; cfg_base[17] = 16'h0300;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_q0();
        t_drop_and_resume();
        t_lo_group();
        t_high_queue();
        t_w1c();
        t_disable();
        t_mask();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule